// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Error Detection

This block turns an asynchronous serial input line into data words. The frame format is set by configuration inputs. A frame has one start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two stop bits. Bit timing comes from an internal tick generator: it divides the system clock so that sixteen ticks make one bit period. For a system clock `fclk` and a line rate `baud`, the divisor to program is `round(fclk / (16 * baud)) - 1`. As an example, 40 MHz and 115200 baud give 21.

Completed words go into a 16-entry first-in first-out store. The surrounding logic reads that store through a show-ahead read port. Four error conditions are kept as sticky flags until a status-read strobe clears them: overrun, parity mismatch, bad stop bit, and a break (the line held low for longer than a whole frame). A level output, the receive time-out, tells the reader that words are waiting but the line has delivered nothing new for three frame times.

Top module: `srx_receiver`

## Requirements
- R1: After reset the store is empty (`fifo_empty_o`=1, `fifo_count_o`=0), and all four error flags and `timeout_o` read 0.
- R2: `cfg_data_len` code 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Bits arrive least significant first, and the unused upper bits of a stored word read 0.
- R3: With `cfg_parity_en`=1 a parity bit follows the data. With `cfg_parity_odd`=0 the data bits plus the parity bit must hold an even number of ones; with 1 they must hold an odd number. A mismatch sets `err_parity_o`, and the word is still stored.
- R4: With `cfg_two_stop`=1 both stop bits are checked, otherwise one is checked. Any stop bit sampled low sets `err_frame_o`, and the word is still stored.
- R5: A low pulse on the line that is high again at the eighth tick after the falling edge is a false start. Nothing is stored and no flag changes.
- R6: The store holds up to 16 words and returns them in arrival order. `rd_en_i` removes the word shown on `rd_data_o`, and `fifo_full_o` is 1 at 16 words.
- R7: A word that completes while the store is full is discarded, the stored words are kept, and `err_overrun_o` is set.
- R8: `err_break_o` is set when the line stays low for more ticks than one frame of the current format lasts (16 ticks per bit). A normal frame of all-zero data does not set it.
- R9: `timeout_o` is 1 when the store is not empty and no frame has completed for 3 frame times, counted in ticks. It reads 0 when the store is empty or soon after a new word arrives.
- R10: Each error flag stays set until a one-cycle pulse on `stat_rd_i` clears it. A new error in the same cycle wins over the clear.
- R11: One tick occurs every `cfg_divisor`+1 clock cycles, and a bit lasts 16 ticks. A valid divisor is 1 to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| cfg_divisor | input | 16 | Tick divisor; tick period is value+1 clocks |
| cfg_data_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits checked |
| rd_en_i | input | 1 | Remove the head word from the store |
| rd_data_o | output | 8 | Head word of the store (show-ahead) |
| fifo_empty_o | output | 1 | Store holds no word |
| fifo_full_o | output | 1 | Store holds 16 words |
| fifo_count_o | output | 5 | Number of stored words |
| stat_rd_i | input | 1 | Status read strobe, clears the sticky flags |
| err_overrun_o | output | 1 | Sticky: word lost because the store was full |
| err_parity_o | output | 1 | Sticky: parity mismatch |
| err_frame_o | output | 1 | Sticky: stop bit sampled low |
| err_break_o | output | 1 | Sticky: line low for longer than a frame |
| timeout_o | output | 1 | Words waiting and no new word for 3 frame times |

## Verification
A bit counter or sample phase that is off shows up within one frame as shifted or truncated words on `rd_data_o`, or as a false parity or frame flag. Read and write pointer faults show up as wrong word order within sixteen frames, and the burst of seventeen frames pushes the store to its full boundary. The break and time-out counters are checked on both sides of their limits. The time-out is checked a few dozen clocks before and after its three-frame threshold, and the break is checked against an all-zero data frame, which is one bit shorter than the threshold.

// File: rtl/srx_pkg.sv
// Shared definitions for the serial receiver: oversampling rate, the
// receiver state type and the frame length helper.
package srx_pkg;

    localparam int OS_RATE = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_HOLD
    } rx_state_e;

    // Ticks in one frame: start + (5+len) data + parity + 1 or 2 stop bits.
    function automatic logic [9:0] frame_ticks(input logic [1:0] len,
                                               input logic pen,
                                               input logic two);
        int nbits;
        nbits = 7 + int'(len) + int'(pen) + int'(two);
        return 10'(nbits * OS_RATE);
    endfunction

endpackage

// File: rtl/srx_tick_gen.sv
// Tick generator: one-cycle pulse every (divisor+1) clocks.
// Assumes the divisor changes only while the line is idle.
module srx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Down-counter that reloads from the divisor after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == '0)  cnt_q <= divisor;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/srx_frame_rx.sv
// Frame receiver: finds the start bit, samples every bit in its middle
// (tick count OS_RATE/2 for the start bit, then every OS_RATE ticks),
// and gives a one-cycle push with the word and its parity and stop status.
// Assumes rx_i is already synchronised to clk.
module srx_frame_rx
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic [1:0] cfg_data_len,
    input  logic       cfg_parity_en,
    input  logic       cfg_parity_odd,
    input  logic       cfg_two_stop,
    output logic       push_o,
    output logic [7:0] word_o,
    output logic       perr_o,
    output logic       ferr_o
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] MID  = CW'(OS_RATE/2 - 1);
    localparam logic [CW-1:0] FULL = CW'(OS_RATE - 1);

    rx_state_e     state_q;
    logic [CW-1:0] os_cnt_q;
    logic [2:0]    bit_idx_q;
    logic [7:0]    shreg_q;
    logic          par_acc_q, perr_q, ferr_q;
    logic          at_full, done;
    logic [2:0]    last_idx;

    // Decode of the sample point and the last bit of the frame.
    always_comb begin
        last_idx = 3'd4 + 3'(cfg_data_len);
        at_full  = tick_i && (os_cnt_q == FULL);
        done     = at_full && ((state_q == ST_STOP1 && !cfg_two_stop) ||
                               state_q == ST_STOP2);
    end

    // Frame state machine with oversample counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            os_cnt_q  <= '0;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            push_o    <= 1'b0;
            word_o    <= '0;
            perr_o    <= 1'b0;
            ferr_o    <= 1'b0;
        end else begin
            push_o <= 1'b0;
            if (done) begin
                push_o   <= 1'b1;
                word_o   <= shreg_q;
                perr_o   <= perr_q;
                ferr_o   <= ferr_q | !rx_i;
                os_cnt_q <= '0;
                state_q  <= rx_i ? ST_IDLE : ST_HOLD;
            end else begin
                case (state_q)
                    ST_IDLE: if (!rx_i) begin
                        state_q  <= ST_START;
                        os_cnt_q <= '0;
                    end
                    ST_START: if (tick_i) begin
                        if (os_cnt_q == MID) begin
                            os_cnt_q <= '0;
                            if (rx_i) state_q <= ST_IDLE;
                            else begin
                                state_q   <= ST_DATA;
                                bit_idx_q <= '0;
                                shreg_q   <= '0;
                                par_acc_q <= 1'b0;
                                perr_q    <= 1'b0;
                                ferr_q    <= 1'b0;
                            end
                        end else os_cnt_q <= os_cnt_q + 1'b1;
                    end
                    ST_HOLD: if (rx_i) state_q <= ST_IDLE;
                    default: if (tick_i) begin
                        if (at_full) begin
                            os_cnt_q <= '0;
                            case (state_q)
                                ST_DATA: begin
                                    shreg_q[bit_idx_q] <= rx_i;
                                    par_acc_q          <= par_acc_q ^ rx_i;
                                    if (bit_idx_q == last_idx)
                                        state_q <= cfg_parity_en ? ST_PAR : ST_STOP1;
                                    else
                                        bit_idx_q <= bit_idx_q + 1'b1;
                                end
                                ST_PAR: begin
                                    perr_q  <= (par_acc_q ^ rx_i) != cfg_parity_odd;
                                    state_q <= ST_STOP1;
                                end
                                ST_STOP1: begin
                                    ferr_q  <= !rx_i;
                                    state_q <= ST_STOP2;
                                end
                                default: state_q <= ST_IDLE;
                            endcase
                        end else os_cnt_q <= os_cnt_q + 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_fifo.sv
// Show-ahead word store. A push while full is refused and reported on
// overrun_o. Assumes DEPTH is a power of two.
module srx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [W-1:0]    data_i,
    input  logic            pop_i,
    output logic [W-1:0]    data_o,
    output logic            empty_o,
    output logic            full_o,
    output logic [CNTW-1:0] count_o,
    output logic            overrun_o
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic          do_push, do_pop;

    assign empty_o   = (count_o == '0);
    assign full_o    = (count_o == CNTW'(DEPTH));
    assign do_push   = push_i && !full_o;
    assign do_pop    = pop_i && !empty_o;
    assign overrun_o = push_i && full_o;
    assign data_o    = mem_q[rptr_q];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wptr_q] <= data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            count_o <= count_o + CNTW'(do_push) - CNTW'(do_pop);
        end
    end
endmodule

// File: rtl/srx_receiver.sv
// Serial receiver top: input synchroniser, tick generator, frame
// receiver, word store, sticky error flags, break and time-out counters.
// Assumes the configuration is stable while a frame is in flight.
module srx_receiver
    import srx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_i,
    input  logic [DIV_W-1:0] cfg_divisor,
    input  logic [1:0]       cfg_data_len,
    input  logic             cfg_parity_en,
    input  logic             cfg_parity_odd,
    input  logic             cfg_two_stop,
    input  logic             rd_en_i,
    output logic [7:0]       rd_data_o,
    output logic             fifo_empty_o,
    output logic             fifo_full_o,
    output logic [CNTW-1:0]  fifo_count_o,
    input  logic             stat_rd_i,
    output logic             err_overrun_o,
    output logic             err_parity_o,
    output logic             err_frame_o,
    output logic             err_break_o,
    output logic             timeout_o
);
    logic [1:0]  sync_q;
    logic        rx_s, tick, f_push, f_perr, f_ferr, ovr_evt, brk_evt;
    logic [7:0]  f_word;
    logic [9:0]  ft;
    logic [9:0]  brk_cnt_q;
    logic [10:0] to_cnt_q, to_limit;

    // Two-stage synchroniser for the asynchronous line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd_i};
    end
    assign rx_s = sync_q[1];

    srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(cfg_divisor), .tick_o(tick)
    );

    srx_frame_rx u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s),
        .cfg_data_len(cfg_data_len), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
        .push_o(f_push), .word_o(f_word), .perr_o(f_perr), .ferr_o(f_ferr)
    );

    srx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(f_push), .data_i(f_word),
        .pop_i(rd_en_i), .data_o(rd_data_o), .empty_o(fifo_empty_o),
        .full_o(fifo_full_o), .count_o(fifo_count_o), .overrun_o(ovr_evt)
    );

    assign ft       = frame_ticks(cfg_data_len, cfg_parity_en, cfg_two_stop);
    assign to_limit = 11'(ft) * 11'd3;
    assign brk_evt  = tick && !rx_s && (brk_cnt_q == ft);

    // Low-line length in ticks, saturating one past a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_s)                     brk_cnt_q <= '0;
        else if (tick && brk_cnt_q <= ft)       brk_cnt_q <= brk_cnt_q + 1'b1;
    end

    // Ticks since the last completed frame while words are waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || f_push || fifo_empty_o)   to_cnt_q <= '0;
        else if (tick && to_cnt_q != to_limit)  to_cnt_q <= to_cnt_q + 1'b1;
    end
    assign timeout_o = !fifo_empty_o && (to_cnt_q == to_limit);

    // Sticky error flags: a new event wins over the status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overrun_o <= 1'b0;
            err_parity_o  <= 1'b0;
            err_frame_o   <= 1'b0;
            err_break_o   <= 1'b0;
        end else begin
            err_overrun_o <= (err_overrun_o & !stat_rd_i) | ovr_evt;
            err_parity_o  <= (err_parity_o  & !stat_rd_i) | (f_push & f_perr);
            err_frame_o   <= (err_frame_o   & !stat_rd_i) | (f_push & f_ferr);
            err_break_o   <= (err_break_o   & !stat_rd_i) | brk_evt;
        end
    end
endmodule

// File: rtl/srx_receiver_chk.sv
// Property checker for srx_receiver, attached to every instance by bind.
// Watches the ports and the push strobe and tick from the inner blocks.
module srx_receiver_chk #(
    parameter int DEPTH = 16,
    parameter int CNTW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            f_push,
    input logic [15:0]     cfg_divisor,
    input logic            rd_en_i,
    input logic            stat_rd_i,
    input logic            fifo_empty_o,
    input logic            fifo_full_o,
    input logic [CNTW-1:0] fifo_count_o,
    input logic            err_overrun_o,
    input logic            err_parity_o,
    input logic            err_frame_o,
    input logic            timeout_o
);
    // R11: with a divisor of at least one, ticks never come back to back.
    p_tick_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_divisor != '0) |=> !tick);

    // R6: occupancy never exceeds the depth.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count_o <= CNTW'(DEPTH));

    // R6: full and empty never hold together.
    p_full_not_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_o |-> !fifo_empty_o);

    // R7: a word arriving at a full store leaves the store full.
    p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full_o && f_push && !rd_en_i) |=> (fifo_count_o == CNTW'(DEPTH)));

    // R7: the overrun flag rises only after the store was full.
    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun_o) |-> $past(fifo_full_o));

    // R9: a time-out is never shown for an empty store.
    p_timeout_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !fifo_empty_o);

    // R10: a status read with no frame completing clears parity and frame flags.
    p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !f_push) |=> (!err_parity_o && !err_frame_o));
endmodule

bind srx_receiver srx_receiver_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .f_push(f_push),
    .cfg_divisor(cfg_divisor), .rd_en_i(rd_en_i), .stat_rd_i(stat_rd_i),
    .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o),
    .fifo_count_o(fifo_count_o), .err_overrun_o(err_overrun_o),
    .err_parity_o(err_parity_o), .err_frame_o(err_frame_o),
    .timeout_o(timeout_o)
);

// File: tb/srx_receiver_tb.sv
// Scoreboard bench: the frame driver queues each expected word and a
// monitor pops and compares words as they appear at the read port.
module srx_receiver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [15:0] div = 16'd1;
    logic [1:0]  len = 2'd3;
    logic        pen = 1'b0, podd = 1'b0, two = 1'b0;
    logic        rd_en = 1'b0, stat_rd = 1'b0;
    logic [7:0]  rd_data;
    logic        empty, full, ovr, perr, ferr, brk, tmo;
    logic [4:0]  count;

    int   n_chk = 0, n_fail = 0;
    bit   mon_en = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    srx_receiver u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .cfg_divisor(div),
        .cfg_data_len(len), .cfg_parity_en(pen), .cfg_parity_odd(podd),
        .cfg_two_stop(two), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .fifo_empty_o(empty), .fifo_full_o(full), .fifo_count_o(count),
        .stat_rd_i(stat_rd), .err_overrun_o(ovr), .err_parity_o(perr),
        .err_frame_o(ferr), .err_break_o(brk), .timeout_o(tmo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic int bit_clks();
        return 16 * (int'(div) + 1);
    endfunction

    task automatic drive_bit(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (bit_clks() - 1) @(negedge clk);
    endtask

    // Sends one frame in the current format; queues the expected word.
    task automatic send_frame(input logic [7:0] d, input bit bad_par,
                              input bit bad_stop, input bit queue_it);
        int nb;
        logic [7:0] m;
        logic p;
        nb = 5 + int'(len);
        m  = 8'hFF >> (8 - nb);
        p  = ^(d & m);
        if (podd) p = ~p;
        if (bad_par) p = ~p;
        if (queue_it) exp_q.push_back(d & m);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (pen) drive_bit(p);
        if (two) begin
            drive_bit(1'b1);
            drive_bit(!bad_stop);
        end else drive_bit(!bad_stop);
        drive_bit(1'b1);
    endtask

    task automatic status_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 4000; i++) begin
            if (exp_q.size() == 0 && empty && !rd_en) break;
            @(negedge clk);
        end
        chk(exp_q.size() == 0 && empty, tag, exp_q.size(), 0);
    endtask

    // Monitor: pops one word every other cycle and compares it (R6, R2).
    initial begin
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (rd_en) rd_en = 1'b0;
            else if (mon_en && !empty) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected word", rd_data, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R6 word order/value", rd_data, e);
                end
                rd_en = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(empty && count == 0, "R1 store empty", count, 0);
        chk({ovr, perr, ferr, brk, tmo} == 5'b0, "R1 flags clear",
            {ovr, perr, ferr, brk, tmo}, 0);
        mon_en = 1'b1;

        // R2: 8 data bits, no parity, one stop
        send_frame(8'hA5, 0, 0, 1);
        send_frame(8'h00, 0, 0, 1);
        send_frame(8'hFF, 0, 0, 1);
        send_frame(8'h3C, 0, 0, 1);
        drain("R2 8-bit words");
        // R8: an all-zero data frame is not a break
        chk(!brk && !ferr && !perr, "R8 zero frame no break", {brk, ferr, perr}, 0);

        // R2: 5, 6 and 7 bit lengths, upper bits read zero
        len = 2'd0;
        send_frame(8'hF5, 0, 0, 1);
        send_frame(8'h0A, 0, 0, 1);
        len = 2'd1;
        send_frame(8'hEB, 0, 0, 1);
        len = 2'd2; pen = 1'b1; podd = 1'b1;
        send_frame(8'h5A, 0, 0, 1);
        drain("R2 short words");
        chk(!perr && !ferr, "R3 correct odd parity", {perr, ferr}, 0);

        // R3: wrong even parity sets the flag, word still stored
        podd = 1'b0;
        send_frame(8'h33, 1, 0, 1);
        chk(perr, "R3 parity mismatch flag", perr, 1);
        drain("R3 word kept on parity error");
        repeat (3 * bit_clks()) @(negedge clk);
        chk(perr, "R10 parity flag sticky", perr, 1);
        status_read();
        chk(!perr, "R10 flag cleared by status read", perr, 0);

        // R4: two stop bits
        len = 2'd3; pen = 1'b0; two = 1'b1;
        send_frame(8'h81, 0, 0, 1);
        chk(!ferr, "R4 good two-stop frame", ferr, 0);
        send_frame(8'h7E, 0, 1, 1);
        chk(ferr, "R4 second stop low", ferr, 1);
        drain("R4 words kept");
        status_read();
        two = 1'b0;
        send_frame(8'h42, 0, 1, 1);
        chk(ferr, "R4 single stop low", ferr, 1);
        drain("R4 word kept single stop");
        status_read();
        chk(!ferr, "R10 frame flag cleared", ferr, 0);

        // R5: false start pulse of 4 ticks
        @(negedge clk); rxd = 1'b0;
        repeat (4 * (int'(div) + 1)) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * bit_clks()) @(negedge clk);
        chk(empty && count == 0, "R5 false start stores nothing", count, 0);
        chk({perr, ferr, brk} == 3'b0, "R5 false start no flags", {perr, ferr, brk}, 0);
        send_frame(8'h6D, 0, 0, 1);
        drain("R5 receiver rearmed");

        // R11: slower tick
        div = 16'd3;
        repeat (20) @(negedge clk);
        send_frame(8'h96, 0, 0, 1);
        send_frame(8'h1E, 0, 0, 1);
        drain("R11 divisor 3");
        div = 16'd1;
        repeat (20) @(negedge clk);

        // R9: time-out after 3 frame times (8N1: 480 ticks = 960 clocks)
        mon_en = 1'b0;
        send_frame(8'h11, 0, 0, 1);
        chk(!tmo, "R9 no timeout right after word", tmo, 0);
        repeat (850) @(negedge clk);
        chk(!tmo, "R9 no timeout before limit", tmo, 0);
        repeat (100) @(negedge clk);
        chk(tmo, "R9 timeout after 3 frames", tmo, 1);
        mon_en = 1'b1;
        drain("R9 drain");
        chk(!tmo, "R9 timeout drops when empty", tmo, 0);

        // R8: line low for two frame times
        exp_q.push_back(8'h00);
        @(negedge clk); rxd = 1'b0;
        repeat (2 * 10 * bit_clks()) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bit_clks()) @(negedge clk);
        chk(brk, "R8 break flagged", brk, 1);
        chk(ferr, "R4 break frame has bad stop", ferr, 1);
        drain("R8 break word");
        status_read();
        chk(!brk && !ferr, "R10 break flag cleared", {brk, ferr}, 0);

        // R7: seventeen words into a 16-entry store
        mon_en = 1'b0;
        for (int i = 0; i < 17; i++)
            send_frame(8'(i * 7 + 1), 0, 0, i < 16);
        chk(full && count == 16, "R6 store full at 16", count, 16);
        chk(ovr, "R7 overrun flagged", ovr, 1);
        mon_en = 1'b1;
        drain("R7 first 16 words kept");
        status_read();
        chk(!ovr, "R10 overrun flag cleared", ovr, 0);

        finish_run();
    end
endmodule